// File: doc/BRIEF.md
# Synchronous Serial Transmit Port

This block serialises one data word per frame onto a synchronous three-wire link: a serial clock, a frame sync and a data line. The serial clock comes from a divider on the system clock. The frame sync is generated inside the block. Its active level can be chosen, and it can lead the first data bit by one serial clock (early framing) or coincide with it (late framing). Software or a DMA engine places each word in a one-entry holding register. The port takes that word at the start of each frame.

If a frame is due while the holding register is empty, the port sends the previous word again and raises a sticky underflow flag. The same condition also sets an error line toward the DMA side. To recover, the port is disabled and then enabled again. The flag then drops on the fourth serial clock after the enable. The DMA error can be acknowledged only once the flag is clear. While the port is disabled, the serial clock is held low and produces no pulses at all.

Top module: `sertx_port`

## Requirements
- R1: While enabled, the serial clock has a period of 2×(clk_div+1) system clocks. Its rising edge is the driving edge. The divider register is zero after reset, which gives half the system clock rate, and it takes the clk_div input only in cycles where tx_en is high.
- R2: In every cycle after a system-clock edge at which tx_en was low, sclk is low. Disabling the port stops the serial clock without a final pulse.
- R3: The first rising sclk edge after enabling is slot 0. The frame period is fs_div serial clocks, raised to a minimum of L+1 (early) or L (late), where L is the word length. The frame sync is active for exactly one serial clock, in slot 0 of each frame, and holds its level between rising sclk edges.
- R4: Data goes out MSB first and changes only on rising sclk edges. The word length is word_len_m1+1, and a field value below 2 is treated as 2. With late_frame=0 (early), bits occupy slots 1..L. With late_frame=1 (late), bits occupy slots 0..L-1. sdata is 0 in all other slots and while the port is disabled.
- R5: fsync = (active XOR fs_act_low), in both early and late framing. While the port is disabled, fsync rests at its inactive level, which equals fs_act_low.
- R6: A write (wr_valid) is accepted only while hold_empty is 1; a write while it is 0 is dropped. The held word is consumed at the start of the next frame, which sets hold_empty again.
- R7: At a frame start with an empty holding register, underflow is set on that rising sclk edge, and the word of the previous frame is sent again. After reset that word is zero.
- R8: Underflow stays set while the port is disabled. It clears only on the fourth rising sclk edge after the port is enabled again. A new underflow inside that window cancels the clear.
- R9: dma_err is set whenever underflow is set. A dma_err_ack pulse clears dma_err only if underflow is already 0, and is ignored while underflow is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Port enable |
| clk_div | input | DIV_W | Serial clock divider value |
| fs_div | input | FS_W | Frame period in serial clocks |
| late_frame | input | 1 | 1: late framing, 0: early framing |
| fs_act_low | input | 1 | 1: frame sync active low |
| word_len_m1 | input | 5 | Word length minus one |
| wr_valid | input | 1 | Write strobe for the holding register |
| wr_data | input | 32 | Word to transmit, right-justified |
| dma_err_ack | input | 1 | Acknowledge of the DMA-side error |
| hold_empty | output | 1 | Holding register can take a word |
| sclk | output | 1 | Serial clock |
| fsync | output | 1 | Frame sync |
| sdata | output | 1 | Serial data |
| underflow | output | 1 | Sticky transmit underflow flag |
| dma_err | output | 1 | Error indication toward the DMA side |

## Verification
All outputs are registered. sclk, fsync, sdata and underflow change on the same system-clock edge that makes sclk rise. With tx_en sampled high at one edge, the first rise appears clk_div+1 edges later. hold_empty and dma_err respond one edge after the write or acknowledge that affects them. The bench therefore captures the inputs at each rising edge and compares the outputs at the following falling edge against a model advanced by that same edge. Frame slots, underflow events and the four-edge clear window are counted only at the observed rising sclk edges, so the checks do not depend on any assumed first-rise latency.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    localparam int WORD_W    = 32;
    localparam int LEN_FLD_W = 5;
    localparam int MIN_LEN   = 3;

    typedef enum logic {
        FRAME_EARLY = 1'b0,
        FRAME_LATE  = 1'b1
    } framing_e;

    typedef struct packed {
        framing_e               framing;
        logic                   fs_low;
        logic [LEN_FLD_W-1:0]   len_m1;
    } frame_fmt_t;

    // Word length in bits from the length field, clamped to the minimum.
    function automatic int word_bits(logic [LEN_FLD_W-1:0] fld);
        int n;
        n = int'(fld) + 1;
        return (n < MIN_LEN) ? MIN_LEN : n;
    endfunction

    // Frame period in serial clocks; never shorter than the data it carries.
    function automatic int frame_slots(int fsd, int len, framing_e fr);
        int need;
        need = (fr == FRAME_LATE) ? len : len + 1;
        return (fsd < need) ? need : fsd;
    endfunction

endpackage

// File: rtl/sertx_clkgen.sv
module sertx_clkgen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [DIV_W-1:0] div_in,
    output logic             sclk,
    output logic             tick,
    output logic             en_rise
);
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] cnt_q;
    logic             en_q;
    logic             sclk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q  <= '0;
            cnt_q  <= '0;
            en_q   <= 1'b0;
            sclk_q <= 1'b0;
        end else begin
            en_q <= en;
            if (en) begin
                div_q <= div_in;
            end
            if (!en) begin
                cnt_q  <= '0;
                sclk_q <= 1'b0;
            end else if (!en_q) begin
                cnt_q <= '0;
            end else if (cnt_q == div_q) begin
                cnt_q  <= '0;
                sclk_q <= ~sclk_q;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign sclk    = sclk_q;
    assign tick    = en && en_q && (cnt_q == div_q) && !sclk_q;
    assign en_rise = en && !en_q;

endmodule

// File: rtl/sertx_framer.sv
module sertx_framer
    import sertx_pkg::*;
#(
    parameter int FS_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              tick,
    input  logic [FS_W-1:0]   fs_div,
    input  frame_fmt_t        fmt,
    input  logic              hold_full,
    input  logic [WORD_W-1:0] hold_word,
    output logic              take,
    output logic              uf_event,
    output logic              fsync,
    output logic              sdata
);
    localparam int SLOT_W = (FS_W > 6) ? FS_W : 6;

    logic [SLOT_W-1:0] slot_q;
    logic [SLOT_W-1:0] next_slot;
    logic              started_q;
    logic [WORD_W-1:0] cur_word_q;
    logic [WORD_W-1:0] word_sel;
    logic              at_start;
    logic              bit_v;
    int                len;
    int                per;
    int                bidx;

    always_comb begin
        len = word_bits(fmt.len_m1);
        per = frame_slots(int'(fs_div), len, fmt.framing);
        if (!started_q || int'(slot_q) >= per - 1) begin
            next_slot = '0;
        end else begin
            next_slot = slot_q + 1'b1;
        end
        at_start = tick && (next_slot == '0);
        take     = at_start && hold_full;
        uf_event = at_start && !hold_full;
        word_sel = take ? hold_word : cur_word_q;
        bidx     = (fmt.framing == FRAME_LATE) ? int'(next_slot) : int'(next_slot) - 1;
        if (bidx >= 0 && bidx < len) begin
            bit_v = word_sel[5'(len - 1 - bidx)];
        end else begin
            bit_v = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q     <= '0;
            started_q  <= 1'b0;
            cur_word_q <= '0;
            fsync      <= 1'b0;
            sdata      <= 1'b0;
        end else if (!en) begin
            slot_q    <= '0;
            started_q <= 1'b0;
            fsync     <= fmt.fs_low;
            sdata     <= 1'b0;
        end else if (tick) begin
            started_q <= 1'b1;
            slot_q    <= next_slot;
            if (at_start) begin
                cur_word_q <= word_sel;
            end
            fsync <= (next_slot == '0) ^ fmt.fs_low;
            sdata <= bit_v;
        end
    end

endmodule

// File: rtl/sertx_uflow.sv
module sertx_uflow #(
    parameter int CLR_TICKS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic en_rise,
    input  logic tick,
    input  logic uf_event,
    input  logic dma_ack,
    output logic uflow,
    output logic dma_err
);
    localparam int CW = $clog2(CLR_TICKS + 1);

    logic [CW-1:0] clr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            uflow   <= 1'b0;
            dma_err <= 1'b0;
            clr_q   <= '0;
        end else begin
            if (uf_event) begin
                uflow <= 1'b1;
                clr_q <= '0;
            end else if (en_rise) begin
                clr_q <= CW'(CLR_TICKS);
            end else if (tick && clr_q != '0) begin
                clr_q <= clr_q - 1'b1;
                if (clr_q == CW'(1)) begin
                    uflow <= 1'b0;
                end
            end
            if (uf_event) begin
                dma_err <= 1'b1;
            end else if (dma_ack && !uflow) begin
                dma_err <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/sertx_port.sv
module sertx_port
    import sertx_pkg::*;
#(
    parameter int DIV_W     = 8,
    parameter int FS_W      = 8,
    parameter int CLR_TICKS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_en,
    input  logic [DIV_W-1:0]  clk_div,
    input  logic [FS_W-1:0]   fs_div,
    input  logic              late_frame,
    input  logic              fs_act_low,
    input  logic [4:0]        word_len_m1,
    input  logic              wr_valid,
    input  logic [31:0]       wr_data,
    input  logic              dma_err_ack,
    output logic              hold_empty,
    output logic              sclk,
    output logic              fsync,
    output logic              sdata,
    output logic              underflow,
    output logic              dma_err
);
    frame_fmt_t        fmt;
    logic              tick;
    logic              en_rise;
    logic              take;
    logic              uf_event;
    logic              hold_full;
    logic [WORD_W-1:0] hold_word;

    assign fmt.framing = late_frame ? FRAME_LATE : FRAME_EARLY;
    assign fmt.fs_low  = fs_act_low;
    assign fmt.len_m1  = word_len_m1;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_full <= 1'b0;
            hold_word <= '0;
        end else begin
            if (take) begin
                hold_full <= 1'b0;
            end
            if (wr_valid && !hold_full) begin
                hold_full <= 1'b1;
                hold_word <= wr_data;
            end
        end
    end

    assign hold_empty = !hold_full;

    sertx_clkgen #(.DIV_W(DIV_W)) u_clk (
        .clk     (clk),
        .rst     (rst),
        .en      (tx_en),
        .div_in  (clk_div),
        .sclk    (sclk),
        .tick    (tick),
        .en_rise (en_rise)
    );

    sertx_framer #(.FS_W(FS_W)) u_frm (
        .clk       (clk),
        .rst       (rst),
        .en        (tx_en),
        .tick      (tick),
        .fs_div    (fs_div),
        .fmt       (fmt),
        .hold_full (hold_full),
        .hold_word (hold_word),
        .take      (take),
        .uf_event  (uf_event),
        .fsync     (fsync),
        .sdata     (sdata)
    );

    sertx_uflow #(.CLR_TICKS(CLR_TICKS)) u_uf (
        .clk      (clk),
        .rst      (rst),
        .en_rise  (en_rise),
        .tick     (tick),
        .uf_event (uf_event),
        .dma_ack  (dma_err_ack),
        .uflow    (underflow),
        .dma_err  (dma_err)
    );

endmodule

// File: rtl/sertx_port_chk.sv
module sertx_port_chk (
    input logic clk,
    input logic rst,
    input logic en,
    input logic sclk,
    input logic fsync,
    input logic sdata,
    input logic underflow,
    input logic dma_err
);
    // R2
    sclk_gated_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> !sclk);

    // R3
    fsync_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(en) && !$rose(sclk)) |-> $stable(fsync));

    // R4
    sdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(en) && !$rose(sclk)) |-> $stable(sdata));

    // R7
    uf_on_edge_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(underflow) |-> $rose(sclk));

    // R8
    uf_sticky_off_chk: assert property (@(posedge clk) disable iff (rst)
        (!en && underflow) |=> underflow);

    // R9
    dma_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (underflow && dma_err) |=> dma_err);

endmodule

bind sertx_port sertx_port_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .en        (tx_en),
    .sclk      (sclk),
    .fsync     (fsync),
    .sdata     (sdata),
    .underflow (underflow),
    .dma_err   (dma_err)
);

// File: tb/tb_sertx_port.sv
module tb_sertx_port;
    localparam int CLK_P = 10;
    localparam int WDOG  = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tx_en = 1'b0;
    logic [7:0]  clk_div = '0;
    logic [7:0]  fs_div = '0;
    logic        late_frame = 1'b0;
    logic        fs_act_low = 1'b0;
    logic [4:0]  word_len_m1 = 5'd7;
    logic        wr_valid = 1'b0;
    logic [31:0] wr_data = '0;
    logic        dma_err_ack = 1'b0;
    logic        hold_empty, sclk, fsync, sdata, underflow, dma_err;

    sertx_port dut (
        .clk(clk), .rst(rst), .tx_en(tx_en), .clk_div(clk_div), .fs_div(fs_div),
        .late_frame(late_frame), .fs_act_low(fs_act_low), .word_len_m1(word_len_m1),
        .wr_valid(wr_valid), .wr_data(wr_data), .dma_err_ack(dma_err_ack),
        .hold_empty(hold_empty), .sclk(sclk), .fsync(fsync), .sdata(sdata),
        .underflow(underflow), .dma_err(dma_err)
    );

    always #(CLK_P/2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int bits_of(int fld);
        return (fld + 1 < 3) ? 3 : fld + 1;
    endfunction

    function automatic int period_of(int fsd, int len, bit late);
        int need = late ? len : len + 1;
        return (fsd < need) ? need : fsd;
    endfunction

    function automatic bit exp_bit(logic [31:0] w, int slot, int len, bit late);
        int b = late ? slot : slot - 1;
        if (b < 0 || b >= len) return 1'b0;
        return w[len - 1 - b];
    endfunction

    // inputs seen by the design at each rising edge
    logic        s_en, s_en_prev, s_wr, s_ack, s_late, s_low;
    logic [31:0] s_data;
    logic [7:0]  s_div, s_fsd;
    logic [4:0]  s_len;
    always @(posedge clk) begin
        s_en_prev <= s_en;
        s_en   <= tx_en;
        s_wr   <= wr_valid;
        s_data <= wr_data;
        s_ack  <= dma_err_ack;
        s_late <= late_frame;
        s_low  <= fs_act_low;
        s_div  <= clk_div;
        s_fsd  <= fs_div;
        s_len  <= word_len_m1;
    end

    // reference model, advanced at each falling edge
    bit          mon_on = 1'b0;
    bit          m_full = 1'b0, m_uf = 1'b0, m_dma = 1'b0, m_started = 1'b0;
    logic [31:0] m_hold = '0, m_last = '0;
    int          m_slot = 0, m_arm = 0;
    logic        sclk_prev = 1'b0;
    longint      cyc = 0, last_rise = -1;

    always @(negedge clk) begin
        cyc++;
        if (mon_on) begin
            bit rise, full_b, uf_b, ev;
            int len, per;
            rise   = sclk && !sclk_prev;
            full_b = m_full;
            uf_b   = m_uf;
            ev     = 1'b0;
            len    = bits_of(int'(s_len));
            per    = period_of(int'(s_fsd), len, s_late);
            if (s_en && !s_en_prev) m_arm = 4;
            if (!s_en) begin
                m_started = 1'b0;
                last_rise = -1;
                chk(sclk == 1'b0, "R2 sclk while disabled", int'(sclk), 0);
                chk(fsync == s_low, "R5 idle fsync level", int'(fsync), int'(s_low));
                chk(sdata == 1'b0, "R4 sdata while disabled", int'(sdata), 0);
            end
            if (rise) begin
                if (last_rise >= 0)
                    chk(cyc - last_rise == 2 * (int'(s_div) + 1), "R1 sclk period",
                        int'(cyc - last_rise), 2 * (int'(s_div) + 1));
                last_rise = cyc;
                if (!m_started) begin
                    m_slot = 0;
                    m_started = 1'b1;
                end else begin
                    m_slot = (m_slot >= per - 1) ? 0 : m_slot + 1;
                end
                if (m_slot == 0) begin
                    if (full_b) m_last = m_hold;
                    else ev = 1'b1;
                    m_full = 1'b0;
                end
                chk(fsync == ((m_slot == 0) ^ s_low), "R3 R5 fsync at slot",
                    int'(fsync), int'((m_slot == 0) ^ s_low));
                chk(sdata == exp_bit(m_last, m_slot, len, s_late), "R4 R7 data bit",
                    int'(sdata), int'(exp_bit(m_last, m_slot, len, s_late)));
                if (ev) begin
                    m_uf = 1'b1;
                    m_arm = 0;
                end else if (m_arm > 0) begin
                    m_arm--;
                    if (m_arm == 0) m_uf = 1'b0;
                end
            end
            if (s_wr && !full_b) begin
                m_full = 1'b1;
                m_hold = s_data;
            end
            if (ev) m_dma = 1'b1;
            else if (s_ack && !uf_b) m_dma = 1'b0;
            chk(hold_empty == !m_full, "R6 hold_empty", int'(hold_empty), int'(!m_full));
            chk(underflow == m_uf, "R7 R8 underflow flag", int'(underflow), int'(m_uf));
            chk(dma_err == m_dma, "R9 dma_err", int'(dma_err), int'(m_dma));
        end
        sclk_prev = sclk;
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_cfg(input int dv, input int fsd, input int lm1, input bit late, input bit low);
        clk_div     = 8'(dv);
        fs_div      = 8'(fsd);
        word_len_m1 = 5'(lm1);
        late_frame  = late;
        fs_act_low  = low;
    endtask

    task automatic run(input int ncyc, input int wprob, input int aprob);
        for (int i = 0; i < ncyc; i++) begin
            wr_valid    = (hold_empty && ($urandom % 100 < wprob)) ? 1'b1 : 1'b0;
            wr_data     = $urandom;
            dma_err_ack = ($urandom % 100 < aprob) ? 1'b1 : 1'b0;
            @(negedge clk);
        end
        wr_valid = 1'b0;
        dma_err_ack = 1'b0;
    endtask

    task automatic wait_rise(output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 2000; i++) begin
            logic prev = sclk;
            @(negedge clk);
            if (sclk && !prev) begin
                ok = 1'b1;
                break;
            end
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        idle(4);
        rst = 1'b0;
        @(negedge clk);
        // reset state
        chk(sclk == 0 && fsync == 0 && sdata == 0, "R2 R5 reset pins",
            int'({sclk, fsync, sdata}), 0);
        chk(underflow == 0 && dma_err == 0, "R7 R9 reset flags",
            int'({underflow, dma_err}), 0);
        chk(hold_empty == 1, "R6 reset hold_empty", int'(hold_empty), 1);
        mon_on = 1'b1;
        idle(2);

        // R1: divider register zero after reset gives half the system clock
        set_cfg(0, 12, 7, 1'b0, 1'b0);
        tx_en = 1'b1;
        run(300, 40, 0);
        tx_en = 1'b0;
        idle(20);

        // R5: late framing with active-low frame sync
        set_cfg(2, 14, 11, 1'b1, 1'b1);
        tx_en = 1'b1;
        run(700, 50, 2);
        tx_en = 1'b0;
        idle(20);

        // R3 R4: minimum clamps of word length and frame period
        set_cfg(1, 0, 0, 1'b0, 1'b1);
        tx_en = 1'b1;
        run(400, 60, 0);
        tx_en = 1'b0;
        idle(15);
        set_cfg(0, 0, 31, 1'b1, 1'b0);
        tx_en = 1'b1;
        run(500, 70, 0);
        tx_en = 1'b0;
        idle(15);

        // random configurations
        for (int r = 0; r < 10; r++) begin
            set_cfg(int'($urandom % 4), int'($urandom % 45), int'($urandom % 32),
                    1'($urandom % 2), 1'($urandom % 2));
            idle(3);
            tx_en = 1'b1;
            run(600 + int'($urandom % 300), (r % 3 == 0) ? 5 : 60, 3);
            tx_en = 1'b0;
            idle(10 + int'($urandom % 10));
        end

        // R8 R9 directed: force an underflow, then recover
        begin
            bit ok;
            set_cfg(1, 30, 7, 1'b0, 1'b0);
            idle(3);
            tx_en = 1'b1;
            for (int i = 0; i < 4000 && !underflow; i++) @(negedge clk);
            chk(underflow == 1, "R7 underflow raised", int'(underflow), 1);
            dma_err_ack = 1'b1;
            @(negedge clk);
            dma_err_ack = 1'b0;
            chk(dma_err == 1, "R9 ack ignored while flag set", int'(dma_err), 1);
            tx_en = 1'b0;
            idle(12);
            chk(underflow == 1, "R8 flag held while disabled", int'(underflow), 1);
            wr_valid = 1'b1;
            wr_data  = 32'h0000_00A5;
            @(negedge clk);
            wr_valid = 1'b0;
            tx_en = 1'b1;
            for (int k = 1; k <= 4; k++) begin
                wait_rise(ok);
                chk(ok && underflow == (k < 4), "R8 clear on fourth edge",
                    int'(underflow), int'(k < 4));
            end
            dma_err_ack = 1'b1;
            @(negedge clk);
            dma_err_ack = 1'b0;
            chk(dma_err == 0, "R9 ack after clear", int'(dma_err), 0);
            wr_valid = 1'b1;
            wr_data  = 32'h0000_005A;
            @(negedge clk);
            wr_valid = 1'b1;
            wr_data  = 32'h0000_00FF;
            @(negedge clk);
            wr_valid = 1'b0;
            run(200, 100, 0);
            tx_en = 1'b0;
            idle(10);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (WDOG) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", WDOG, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule